// File: doc/BRIEF.md
# Wake Interrupt Router

This block collects wake events from up to four system-wake channels and from a few always-on peripheral interrupt sources in a power-down domain. Each system-wake channel delivers one-cycle event pulses. Each pulse sets a sticky pending bit, which stays set until software acknowledges it with a write-one-to-clear access. Pending channels that are enabled and routed drive one shared system-wake interrupt. The peripheral sources arrive as level requests, in the order real-time clock, infrared receiver and watchdog. Each one is gated onto its own interrupt output.

A single route register holds two independent groups of enables. The lower half selects which sources are forwarded to the external interrupt path. The upper half selects which sources may raise the common wake request. A source can therefore be masked as an interrupt and still wake the domain. Software reaches the registers through a simple 32-bit request/acknowledge port, which a small state machine sequences.

The port state machine has four states. IDLE waits for a request. A request with the write flag set moves it to WRITE, and one without moves it to READ. In either case the address and write data are captured. WRITE applies the write in one cycle. READ captures the read data. Both then move to ACK, which pulses the acknowledge for one cycle and returns to IDLE. Requests are ignored outside IDLE.

Top module: `wake_route_unit`

## Requirements
- R1: After reset every register reads zero, and bus_ack, sw_irq, peri_irq and wake_req are low.
- R2: A request taken in IDLE produces exactly one acknowledge cycle, two clock edges after the edge that samples it. A request still held while the machine is busy starts no second access. For a read, bus_rdata is valid in the acknowledge cycle.
- R3: A pulse on sw_event[i] sets bit i of the pending register (offset 0x310, bits 0..3 for channels 0..3). The bit stays set until it is cleared.
- R4: A write to offset 0x318 clears each pending bit written as 1 and leaves bits written as 0 unchanged. Offset 0x318 reads zero.
- R5: If an event and a clear hit the same pending bit in the same cycle, the bit stays set.
- R6: sw_irq is high exactly when some channel i has its pending bit, its enable bit (offset 0x314, bit i) and its route bit 8+i all set.
- R7: peri_irq[k] equals peri_level[k] AND route bit k, with k = 0 for the real-time clock, 1 for infrared and 2 for the watchdog.
- R8: wake_req is the OR over peripheral sources k of peri_level[k] AND route bit 16+k, and over channels i of pending[i] AND route bit 24+i. It does not depend on the enable register or on route bits 0..11.
- R9: The route register (offset 0x31C) keeps its external and wake groups as independent bits. Writes store only the implemented bits (0x0F070F07 at default parameters), and the other bits read zero.
- R10: The pending register is read-only: writes to 0x310 leave it unchanged. Unmapped offsets read zero and ignore writes.
- R11: The enable register is read/write for bits 0..NUM_SW-1, and its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, sampled in IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle access completion |
| sw_event | input | NUM_SW | One-cycle event pulses per system-wake channel |
| peri_level | input | NUM_PERI | Peripheral interrupt levels (RTC, IR, watchdog) |
| sw_irq | output | 1 | Shared system-wake interrupt |
| peri_irq | output | NUM_PERI | Gated peripheral interrupts |
| wake_req | output | 1 | Common wake request |

## Verification
The bench targets an event arriving in the same cycle as its clear. A design that gives the clear priority would lose that event, and the pending bit would read back as zero. It checks that wake_req follows the wake group alone, with the enable register and the external bits zero. A design that mixes the two route groups would then leave the wake request low. It also writes all ones to the route and enable registers and to the read-only pending register. A design that stores unimplemented bits, or that lets software set pending bits, would return the wrong value on read-back. Finally, it holds a request across a busy access. A design that accepts requests outside IDLE would acknowledge twice.

// File: rtl/wru_pkg.sv
package wru_pkg;
    localparam int DATA_W       = 32;
    localparam int OFS_PENDING  = 'h310;
    localparam int OFS_ENABLE   = 'h314;
    localparam int OFS_CLEAR    = 'h318;
    localparam int OFS_ROUTE    = 'h31C;
    localparam int EXT_SW_LSB   = 8;
    localparam int WAKE_LSB     = 16;
    localparam int WAKE_SW_LSB  = WAKE_LSB + EXT_SW_LSB;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_ACK   = 2'd3
    } port_state_t;

    function automatic logic [DATA_W-1:0] route_mask(input int nperi, input int nsw);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < nperi; k++) begin
            m[k]            = 1'b1;
            m[WAKE_LSB + k] = 1'b1;
        end
        for (int i = 0; i < nsw; i++) begin
            m[EXT_SW_LSB + i]  = 1'b1;
            m[WAKE_SW_LSB + i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/wru_port_fsm.sv
module wru_port_fsm
    import wru_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_value,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              acc_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);
    port_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = we ? ST_WRITE : ST_READ;
            ST_WRITE: state_d = ST_ACK;
            ST_READ:  state_d = ST_ACK;
            ST_ACK:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_wdata <= '0;
            rdata     <= '0;
        end else begin
            if (state_q == ST_IDLE && req) begin
                acc_addr  <= addr;
                acc_wdata <= wdata;
            end
            if (state_q == ST_READ) begin
                rdata <= rd_value;
            end
        end
    end

    always_comb begin
        acc_wr = 1'b0;
        ack    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: acc_wr = 1'b1;
            ST_READ:  ;
            ST_ACK:   ack = 1'b1;
        endcase
    end

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_write_then_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> ack);
endmodule

// File: rtl/wru_pending.sv
module wru_pending
    import wru_pkg::*;
#(
    parameter int NUM_SW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] sw_event,
    input  logic [NUM_SW-1:0] clr_bits,
    input  logic              en_wr,
    input  logic [NUM_SW-1:0] en_wdata,
    output logic [NUM_SW-1:0] pending_q,
    output logic [NUM_SW-1:0] enable_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr) begin
            enable_q <= en_wdata;
        end
    end

    for (genvar i = 0; i < NUM_SW; i++) begin : g_chan
        // the event term comes last so that it wins over a clear in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending_q[i] <= 1'b0;
            end else begin
                pending_q[i] <= (pending_q[i] & ~clr_bits[i]) | sw_event[i];
            end
        end

        assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (pending_q[i] && !clr_bits[i]) |=> pending_q[i]);
        assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            sw_event[i] |=> pending_q[i]);
        assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_bits[i] && !sw_event[i]) |=> !pending_q[i]);
    end
endmodule

// File: rtl/wru_route.sv
module wru_route
    import wru_pkg::*;
#(
    parameter int NUM_SW   = 4,
    parameter int NUM_PERI = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                route_wr,
    input  logic [DATA_W-1:0]   route_wdata,
    input  logic [NUM_SW-1:0]   pending,
    input  logic [NUM_SW-1:0]   enable,
    input  logic [NUM_PERI-1:0] peri_level,
    output logic [DATA_W-1:0]   route_q,
    output logic                sw_irq,
    output logic [NUM_PERI-1:0] peri_irq,
    output logic                wake_req
);
    localparam logic [DATA_W-1:0] MASK = route_mask(NUM_PERI, NUM_SW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (route_wr) begin
            route_q <= route_wdata & MASK;
        end
    end

    logic [NUM_SW-1:0] sw_ext_en, sw_wake_en;
    logic [NUM_PERI-1:0] peri_ext_en, peri_wake_en;
    assign sw_ext_en    = route_q[EXT_SW_LSB +: NUM_SW];
    assign sw_wake_en   = route_q[WAKE_SW_LSB +: NUM_SW];
    assign peri_ext_en  = route_q[0 +: NUM_PERI];
    assign peri_wake_en = route_q[WAKE_LSB +: NUM_PERI];

    always_comb begin
        sw_irq   = |(pending & enable & sw_ext_en);
        peri_irq = peri_level & peri_ext_en;
        wake_req = |(peri_level & peri_wake_en) | |(pending & sw_wake_en);
    end

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_irq |-> |(pending & enable));
    assert_wake_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q[DATA_W-1:WAKE_LSB] == '0) |-> !wake_req);
    for (genvar k = 0; k < NUM_PERI; k++) begin : g_peri
        assert_peri_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            peri_irq[k] |-> peri_level[k]);
    end
endmodule

// File: rtl/wake_route_unit.sv
module wake_route_unit
    import wru_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_SW   = 4,
    parameter int NUM_PERI = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ack,
    input  logic [NUM_SW-1:0]   sw_event,
    input  logic [NUM_PERI-1:0] peri_level,
    output logic                sw_irq,
    output logic [NUM_PERI-1:0] peri_irq,
    output logic                wake_req
);
    logic [ADDR_W-1:0]  acc_addr;
    logic [DATA_W-1:0]  acc_wdata, rd_value, route_q;
    logic               acc_wr;
    logic [NUM_SW-1:0]  pending_q, enable_q, clr_bits;
    logic               hit_enable, hit_clear, hit_route, hit_pending;

    assign hit_pending = (acc_addr == ADDR_W'(OFS_PENDING));
    assign hit_enable  = (acc_addr == ADDR_W'(OFS_ENABLE));
    assign hit_clear   = (acc_addr == ADDR_W'(OFS_CLEAR));
    assign hit_route   = (acc_addr == ADDR_W'(OFS_ROUTE));
    assign clr_bits    = (acc_wr && hit_clear) ? acc_wdata[NUM_SW-1:0] : '0;

    always_comb begin
        rd_value = '0;
        if (hit_pending) rd_value[NUM_SW-1:0] = pending_q;
        if (hit_enable)  rd_value[NUM_SW-1:0] = enable_q;
        if (hit_route)   rd_value             = route_q;
    end

    wru_port_fsm #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rd_value(rd_value), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_wr(acc_wr), .rdata(bus_rdata), .ack(bus_ack)
    );

    wru_pending #(.NUM_SW(NUM_SW)) u_pending (
        .clk(clk), .rst_n(rst_n), .sw_event(sw_event), .clr_bits(clr_bits),
        .en_wr(acc_wr && hit_enable), .en_wdata(acc_wdata[NUM_SW-1:0]),
        .pending_q(pending_q), .enable_q(enable_q)
    );

    wru_route #(.NUM_SW(NUM_SW), .NUM_PERI(NUM_PERI)) u_route (
        .clk(clk), .rst_n(rst_n), .route_wr(acc_wr && hit_route),
        .route_wdata(acc_wdata), .pending(pending_q), .enable(enable_q),
        .peri_level(peri_level), .route_q(route_q), .sw_irq(sw_irq),
        .peri_irq(peri_irq), .wake_req(wake_req)
    );

    assert_pending_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit_pending && sw_event == '0) |=> $stable(pending_q));
endmodule

// File: tb/wake_route_unit_test.sv
`timescale 1ns/1ps
module wake_route_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [3:0]  sw_event = '0;
    logic [2:0]  peri_level = '0;
    logic        sw_irq, wake_req;
    logic [2:0]  peri_irq;
    int          n_checks = 0, n_fail = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    wake_route_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .sw_event(sw_event), .peri_level(peri_level),
        .sw_irq(sw_irq), .peri_irq(peri_irq), .wake_req(wake_req)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk); bus_req = 1'b0;
        @(negedge clk); d = bus_rdata;
    endtask

    task automatic pulse_event(input logic [3:0] e);
        @(negedge clk); sw_event = e;
        @(negedge clk); sw_event = '0;
    endtask

    // {write, requirement, offset, write data or expected read data}
    localparam logic [48:0] VEC [13] = '{
        {1'b0, 4'd1,  12'h310, 32'h0000_0000},  // R1 pending after reset
        {1'b0, 4'd1,  12'h314, 32'h0000_0000},  // R1 enable after reset
        {1'b0, 4'd4,  12'h318, 32'h0000_0000},  // R4 clear reads zero
        {1'b0, 4'd1,  12'h31C, 32'h0000_0000},  // R1 route after reset
        {1'b1, 4'd9,  12'h31C, 32'hFFFF_FFFF},
        {1'b0, 4'd9,  12'h31C, 32'h0F07_0F07},  // R9 implemented route bits only
        {1'b1, 4'd11, 12'h314, 32'hFFFF_FFFF},
        {1'b0, 4'd11, 12'h314, 32'h0000_000F},  // R11 enable width
        {1'b1, 4'd10, 12'h310, 32'h0000_000F},
        {1'b0, 4'd10, 12'h310, 32'h0000_0000},  // R10 pending is read-only
        {1'b1, 4'd10, 12'h300, 32'hFFFF_FFFF},
        {1'b0, 4'd10, 12'h300, 32'h0000_0000},  // R10 unmapped offset
        {1'b1, 4'd9,  12'h31C, 32'h0000_0000}
    };

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs at reset
        check("R1 bus_ack", {31'b0, bus_ack}, 32'h0);
        check("R1 irq/wake", {28'b0, sw_irq, peri_irq}, 32'h0);
        check("R1 wake_req", {31'b0, wake_req}, 32'h0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            if (VEC[i][48]) begin
                bus_write(VEC[i][43:32], VEC[i][31:0]);
            end else begin
                bus_read(VEC[i][43:32], rd);
                check($sformatf("R%0d table row %0d", VEC[i][47:44], i), rd, VEC[i][31:0]);
            end
        end
        bus_write(12'h314, 32'h0);

        // R2 request held across the busy states gives one acknowledge
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h31C; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
        check("R2 ack in third cycle", {31'b0, bus_ack}, 32'h1);
        @(negedge clk); check("R2 ack is one cycle", {31'b0, bus_ack}, 32'h0);
        @(negedge clk); check("R2 no second access", {31'b0, bus_ack}, 32'h0);

        // R7 peripheral gating: route bit0 only (RTC)
        peri_level = 3'b101;
        @(negedge clk); check("R7 peri_irq RTC only", {29'b0, peri_irq}, 32'h1);
        bus_write(12'h31C, 32'h0000_0006);
        check("R7 peri_irq WD only", {29'b0, peri_irq}, 32'h4);
        check("R8 ext bits do not wake", {31'b0, wake_req}, 32'h0);
        peri_level = 3'b000;

        // R3 event on channel 2 is sticky
        bus_write(12'h31C, 32'h0000_0000);
        pulse_event(4'b0100);
        repeat (4) @(negedge clk);
        bus_read(12'h310, rd); check("R3 pending ch2 sticky", rd, 32'h4);
        check("R6 no irq with enable off", {31'b0, sw_irq}, 32'h0);

        // R6 irq needs enable and external route bit
        bus_write(12'h314, 32'h4);
        check("R6 no irq without route bit 10", {31'b0, sw_irq}, 32'h0);
        bus_write(12'h31C, 32'h0000_0400);
        check("R6 irq with pending, enable, route", {31'b0, sw_irq}, 32'h1);

        // R4 clear of zero leaves bit, clear of one removes it
        bus_write(12'h318, 32'h0000_000B);
        bus_read(12'h310, rd); check("R4 clear of other bits", rd, 32'h4);
        bus_write(12'h318, 32'h0000_0004);
        bus_read(12'h310, rd); check("R4 clear of ch2", rd, 32'h0);
        check("R6 irq drops after clear", {31'b0, sw_irq}, 32'h0);

        // R5 event and clear on the same edge
        pulse_event(4'b0010);
        @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h318; bus_wdata = 32'h2;
        @(negedge clk); bus_req = 1'b0; bus_we = 1'b0; sw_event = 4'b0010;
        @(negedge clk); sw_event = 4'b0000;
        bus_read(12'h310, rd); check("R5 event wins over clear", rd, 32'h2);

        // R8 wake from a channel with enable and external bits off
        bus_write(12'h314, 32'h0);
        bus_write(12'h31C, 32'h0200_0000);
        check("R8 wake from pending ch1", {31'b0, wake_req}, 32'h1);
        check("R6 irq off with enable off", {31'b0, sw_irq}, 32'h0);
        bus_write(12'h31C, 32'h0002_0000);
        check("R8 ch1 wake bit off", {31'b0, wake_req}, 32'h0);
        peri_level = 3'b010;
        @(negedge clk); check("R8 wake from IR level", {31'b0, wake_req}, 32'h1);
        check("R9 IR interrupt masked while wake set", {29'b0, peri_irq}, 32'h0);
        bus_read(12'h31C, rd); check("R9 route read back", rd, 32'h0002_0000);
        peri_level = 3'b000;
        @(negedge clk); check("R8 wake drops with level", {31'b0, wake_req}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule